// File: doc/BRIEF.md
# Wide-State Hash Absorb and Finalize Sequencer

This block runs one hash instance over a state made of three word banks: a 12-word bank A and two 16-word banks B and C. It also keeps a 64-bit block counter. Whole 16-word message blocks come in through a valid/ready handshake. For each block the sequencer mixes the message into the state, runs a 48-step keyed permutation, removes the message from C, exchanges B and C, and advances the counter. A finish request builds a one-word padding block and runs the final passes. The block then streams the digest out one 32-bit word per cycle.

Two digest sizes are supported, 256 and 512 bits, and each has its own starting constants. After the last digest word the state reloads itself for the same size. A new message can then follow without any further command. Input must arrive as whole blocks.

Top module: `mix_hash_ctrl`

## Requirements
- R1: After reset, blk_ready_o is 1 and dig_valid_o is 0. The state holds the 256-bit starting constants, and the counter W holds {32'h0, CNT_LO_INIT} (default low word 1).
- R2: A pulse on init_i while idle, with blk_valid_i low, loads the starting constants of the size given by wide_i (0 = 256-bit, 1 = 512-bit). It also resets W to {32'h0, CNT_LO_INIT}.
- R3: A block is taken when blk_valid_i and blk_ready_o are both 1. Message word j sits at blk_data_i[32j+31:32j]. blk_ready_o then stays 0 for 50 cycles while the block is processed.
- R4: Absorbing a block performs these steps in order:
  - B[j] += M[j];
  - A[0] ^= W[31:0] and A[1] ^= W[63:32];
  - run the permutation;
  - C[j] -= M[j];
  - exchange B and C word by word;
  - W += 1.
- R5: W is a 64-bit counter: a carry out of its low 32 bits increments its high 32 bits.
- R6: fin_i is taken only while idle and blk_valid_i is low. The final block has word 0 = ((fin_ub_i & -z) | z) & 8'hFF with z = 8'h80 >> fin_n_i, and every other word 0.
- R7: For the final block the sequencer does the B add, the W XOR and the permutation, with no C subtraction and no W increment. Three passes of (B/C exchange, W XOR, permutation) follow, and they reuse the final block words.
- R8: The digest is B[0..15] in 512-bit mode and B[8..15] in 256-bit mode. It comes out one word per cycle in ascending index order with dig_valid_o high, and dig_last_o is high only on the final word.
- R9: blk_valid_i, fin_i and init_i have no effect while a block, a finalization or the digest output is in progress.
- R10: The cycle after the last digest word, the state holds the starting constants of the same size, W is reset, and blk_ready_o is 1.
- R11: While idle, a block takes priority over init_i, and init_i takes priority over fin_i. An input that loses is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Reload starting constants while idle |
| wide_i | input | 1 | Size selected by init_i: 0 = 256-bit, 1 = 512-bit |
| blk_valid_i | input | 1 | Message block valid |
| blk_ready_o | output | 1 | Idle and able to take a block |
| blk_data_i | input | 512 | 16 message words, word j at bits 32j+31:32j |
| fin_i | input | 1 | Finish request |
| fin_ub_i | input | 8 | Extra bits placed above the padding marker |
| fin_n_i | input | 3 | Count of extra bits; the marker is 8'h80 >> fin_n_i |
| dig_valid_o | output | 1 | Digest word valid |
| dig_word_o | output | 32 | Digest word |
| dig_last_o | output | 1 | Final digest word |

## Verification
The hardest case to reach is the carry from the low counter word into the high word, which at the default start value needs 2^32 blocks. The bench sets CNT_LO_INIT to 32'hFFFF_FFFE, so the second absorbed block after every reload crosses the carry, and every digest after that depends on the high word. The bench also drives junk blocks and conflicting finish and reload pulses in the middle of the permutation. It then checks that the digest still matches a reference that never saw them.

// File: rtl/mhc_pkg.sv
package mhc_pkg;
  localparam int WORD_W = 32;
  localparam int N_A    = 12;
  localparam int N_BC   = 16;
  localparam int STEPS  = 3 * N_BC;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [2:0] {ST_IDLE, ST_PREP, ST_PERM, ST_MIX, ST_OUT} state_e;

  localparam word_t A256 [N_A] = '{
    32'h52F84552, 32'hE54B7999, 32'h2D8EE3EC, 32'hB9645191, 32'hE0078B86, 32'hBB7C44C9,
    32'hD2B5C1CA, 32'hB0D2EB8C, 32'h14CE5A45, 32'h22AF50DC, 32'hEFFDBC6B, 32'hEB21B74A};
  localparam word_t B256 [N_BC] = '{
    32'hB555C6EE, 32'h3E710596, 32'hA72A652F, 32'h9301515F, 32'hDA28C1FA, 32'h696FD868,
    32'h9CB6BF72, 32'h0AFE4002, 32'hA6E03615, 32'h5138C1D4, 32'hBE216306, 32'hB38B8890,
    32'h3EA8B96B, 32'h3299ACE4, 32'h30924DD4, 32'h55CB34A5};
  localparam word_t C256 [N_BC] = '{
    32'hB405F031, 32'hC4233EBA, 32'hB3733979, 32'hC0DD9D55, 32'hC51C28AE, 32'hA327B8E1,
    32'h56C56167, 32'hED614433, 32'h88B59D60, 32'h60E2CEBA, 32'h758B4B8B, 32'h83E82A7F,
    32'hBC968828, 32'hE6E00BF7, 32'hBA839E55, 32'h9B491C60};
  localparam word_t A512 [N_A] = '{
    32'h20728DFD, 32'h46C0BD53, 32'hE782B699, 32'h55304632, 32'h71B4EF90, 32'h0EA9E82C,
    32'hDBB930F1, 32'hFAD06B8B, 32'hBE0CAE40, 32'h8BD14410, 32'h76D2ADAC, 32'h28ACAB7F};
  localparam word_t B512 [N_BC] = '{
    32'hC1099CB7, 32'h07B385F3, 32'hE7442C26, 32'hCC8AD640, 32'hEB6F56C7, 32'h1EA81AA9,
    32'h73B9D314, 32'h1DE85D08, 32'h48910A5A, 32'h893B22DB, 32'hC5A0DF44, 32'hBBC4324E,
    32'h72D2F240, 32'h75941D99, 32'h6D8BDE82, 32'hA1A7502B};
  localparam word_t C512 [N_BC] = '{
    32'hD9BF68D1, 32'h58BAD750, 32'h56028CB2, 32'h8134F359, 32'hB5D469D8, 32'h941A8CC2,
    32'h418B2A6E, 32'h04052780, 32'h7F07D787, 32'h5194358F, 32'h3C60D665, 32'hBE97D79A,
    32'h950C3434, 32'hAED9A06D, 32'h2537DC8D, 32'h7CDB5969};

  function automatic word_t rotl(word_t x, int unsigned r);
    return (x << r) | (x >> (WORD_W - r));
  endfunction

  function automatic word_t pad_word(logic [7:0] ub, logic [2:0] n);
    logic [7:0] z;
    z = 8'h80 >> n;
    return {24'd0, (ub & (~z + 8'd1)) | z};
  endfunction
endpackage

// File: rtl/mhc_iv_sel.sv
module mhc_iv_sel
  import mhc_pkg::*;
(
  input  logic  wide_i,
  output word_t iv_a_o [N_A],
  output word_t iv_b_o [N_BC],
  output word_t iv_c_o [N_BC]
);
  for (genvar k = 0; k < N_A; k++) begin : g_a
    assign iv_a_o[k] = wide_i ? A512[k] : A256[k];
  end
  for (genvar k = 0; k < N_BC; k++) begin : g_bc
    assign iv_b_o[k] = wide_i ? B512[k] : B256[k];
    assign iv_c_o[k] = wide_i ? C512[k] : C256[k];
  end
endmodule

// File: rtl/mhc_perm_elt.sv
module mhc_perm_elt
  import mhc_pkg::*;
(
  input  word_t a_cur_i,
  input  word_t a_prev_i,
  input  word_t b_cur_i,
  input  word_t b_p13_i,
  input  word_t b_p9_i,
  input  word_t b_p6_i,
  input  word_t c_i,
  input  word_t m_i,
  output word_t a_o,
  output word_t b_o
);
  word_t r15, x5, u, u3;
  always_comb begin
    r15 = rotl(a_prev_i, 15);
    x5  = r15 + (r15 << 2);
    u   = a_cur_i ^ c_i ^ x5;
    u3  = u + (u << 1);
    a_o = m_i ^ b_p13_i ^ (b_p9_i & ~b_p6_i) ^ u3;
    b_o = ~(rotl(b_cur_i, 1) ^ a_o);
  end
endmodule

// File: rtl/mix_hash_ctrl.sv
module mix_hash_ctrl
  import mhc_pkg::*;
#(
  parameter logic [31:0] CNT_LO_INIT = 32'd1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         wide_i,
  input  logic         blk_valid_i,
  output logic         blk_ready_o,
  input  logic [511:0] blk_data_i,
  input  logic         fin_i,
  input  logic [7:0]   fin_ub_i,
  input  logic [2:0]   fin_n_i,
  output logic         dig_valid_o,
  output logic [31:0]  dig_word_o,
  output logic         dig_last_o
);
  localparam logic [63:0] W_INIT = {32'd0, CNT_LO_INIT};
  localparam int STEP_W = $clog2(STEPS);

  state_e             st_q;
  word_t              a_q [N_A];
  word_t              b_q [N_BC];
  word_t              c_q [N_BC];
  word_t              m_q [N_BC];
  logic [63:0]        w_q;
  logic               wide_q, fin_q;
  logic [1:0]         xr_q;
  logic [STEP_W-1:0]  step_q;
  logic [3:0]         oidx_q;

  word_t iv_a [N_A];
  word_t iv_b [N_BC];
  word_t iv_c [N_BC];
  word_t elt_a, elt_b;
  logic  rom_wide;
  logic [3:0] csel;

  assign rom_wide = (st_q == ST_OUT) ? wide_q : wide_i;
  // C is read backward against the step index: (8 - j) mod 16
  assign csel = 4'(8 - {28'd0, step_q[3:0]});

  mhc_iv_sel u_iv (.wide_i(rom_wide), .iv_a_o(iv_a), .iv_b_o(iv_b), .iv_c_o(iv_c));

  // A and B rotate one slot per step, so the element taps are fixed slots
  mhc_perm_elt u_elt (
    .a_cur_i(a_q[0]), .a_prev_i(a_q[N_A-1]),
    .b_cur_i(b_q[0]), .b_p13_i(b_q[13]), .b_p9_i(b_q[9]), .b_p6_i(b_q[6]),
    .c_i(c_q[csel]), .m_i(m_q[0]), .a_o(elt_a), .b_o(elt_b)
  );

  assign blk_ready_o = (st_q == ST_IDLE);
  assign dig_valid_o = (st_q == ST_OUT);
  assign dig_word_o  = b_q[oidx_q];
  assign dig_last_o  = (st_q == ST_OUT) && (oidx_q == 4'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      a_q  <= A256;
      b_q  <= B256;
      c_q  <= C256;
      m_q  <= '{default: '0};
      w_q  <= W_INIT;
      wide_q <= 1'b0;
      fin_q  <= 1'b0;
      xr_q   <= '0;
      step_q <= '0;
      oidx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (blk_valid_i) begin
            for (int j = 0; j < N_BC; j++) m_q[j] <= blk_data_i[32*j +: 32];
            fin_q <= 1'b0;
            st_q  <= ST_PREP;
          end else if (init_i) begin
            wide_q <= wide_i;
            a_q <= iv_a; b_q <= iv_b; c_q <= iv_c;
            w_q <= W_INIT;
          end else if (fin_i) begin
            m_q    <= '{default: '0};
            m_q[0] <= pad_word(fin_ub_i, fin_n_i);
            fin_q  <= 1'b1;
            xr_q   <= '0;
            st_q   <= ST_PREP;
          end
        end
        ST_PREP: begin
          for (int j = 0; j < N_BC; j++) begin
            if (fin_q && xr_q != 2'd0) begin
              b_q[j] <= rotl(c_q[j], 17);
              c_q[j] <= b_q[j];
            end else begin
              b_q[j] <= rotl(b_q[j] + m_q[j], 17);
            end
          end
          a_q[0] <= a_q[0] ^ w_q[31:0];
          a_q[1] <= a_q[1] ^ w_q[63:32];
          step_q <= '0;
          st_q   <= ST_PERM;
        end
        ST_PERM: begin
          for (int k = 0; k < N_A-1; k++) a_q[k] <= a_q[k+1];
          a_q[N_A-1] <= elt_a;
          for (int k = 0; k < N_BC-1; k++) begin
            b_q[k] <= b_q[k+1];
            m_q[k] <= m_q[k+1];
          end
          b_q[N_BC-1] <= elt_b;
          m_q[N_BC-1] <= m_q[0];
          step_q <= step_q + 1'b1;
          if (step_q == STEP_W'(STEPS-1)) st_q <= ST_MIX;
        end
        ST_MIX: begin
          for (int k = 0; k < N_A; k++)
            a_q[k] <= a_q[k] + c_q[(k+3)%N_BC] + c_q[(k+11)%N_BC] + c_q[(k+15)%N_BC];
          if (!fin_q) begin
            for (int j = 0; j < N_BC; j++) begin
              b_q[j] <= c_q[j] - m_q[j];
              c_q[j] <= b_q[j];
            end
            w_q  <= w_q + 64'd1;
            st_q <= ST_IDLE;
          end else if (xr_q == 2'd3) begin
            oidx_q <= wide_q ? 4'd0 : 4'd8;
            st_q   <= ST_OUT;
          end else begin
            xr_q <= xr_q + 2'd1;
            st_q <= ST_PREP;
          end
        end
        ST_OUT: begin
          oidx_q <= oidx_q + 4'd1;
          if (oidx_q == 4'd15) begin
            a_q <= iv_a; b_q <= iv_b; c_q <= iv_c;
            w_q   <= W_INIT;
            fin_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mhc_chk.sv
module mhc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        blk_valid_i,
  input logic        blk_ready_i,
  input logic        dig_valid_i,
  input logic        dig_last_i,
  input logic [63:0] w_i
);
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && blk_ready_i) |=> !blk_ready_i); // R3
  AST_W_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(w_i[31:0]) == 32'hFFFF_FFFF && w_i[31:0] == 32'd0)
      |-> w_i[63:32] == $past(w_i[63:32]) + 32'd1); // R5
  AST_LAST_IN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_last_i |-> dig_valid_i); // R8
  AST_OUT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_valid_i |-> !blk_ready_i); // R9
  AST_READY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_last_i |=> (blk_ready_i && !dig_valid_i)); // R10
endmodule

bind mix_hash_ctrl mhc_chk u_mhc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .blk_valid_i(blk_valid_i), .blk_ready_i(blk_ready_o),
  .dig_valid_i(dig_valid_o), .dig_last_i(dig_last_o), .w_i(w_q)
);

// File: tb/test_mix_hash_ctrl.sv
`timescale 1ns/1ps
module test_mix_hash_ctrl;
  localparam logic [31:0] LO0 = 32'hFFFF_FFFE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init = 0, wide = 0, blk_valid = 0, fin = 0;
  logic [511:0] blk_data = '0;
  logic [7:0] fin_ub = 0;
  logic [2:0] fin_n = 0;
  logic blk_ready, dig_valid, dig_last;
  logic [31:0] dig_word;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mix_hash_ctrl #(.CNT_LO_INIT(LO0)) i_mix_hash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .wide_i(wide),
    .blk_valid_i(blk_valid), .blk_ready_o(blk_ready), .blk_data_i(blk_data),
    .fin_i(fin), .fin_ub_i(fin_ub), .fin_n_i(fin_n),
    .dig_valid_o(dig_valid), .dig_word_o(dig_word), .dig_last_o(dig_last));

  // ---------------- reference model ----------------
  logic [31:0] ra [12], rb [16], rc [16], rm [16], ex [16];
  logic [63:0] rw;
  logic        rwide;

  logic [31:0] ta256 [12] = '{32'h52F84552,32'hE54B7999,32'h2D8EE3EC,32'hB9645191,32'hE0078B86,32'hBB7C44C9,
                              32'hD2B5C1CA,32'hB0D2EB8C,32'h14CE5A45,32'h22AF50DC,32'hEFFDBC6B,32'hEB21B74A};
  logic [31:0] tb256 [16] = '{32'hB555C6EE,32'h3E710596,32'hA72A652F,32'h9301515F,32'hDA28C1FA,32'h696FD868,
                              32'h9CB6BF72,32'h0AFE4002,32'hA6E03615,32'h5138C1D4,32'hBE216306,32'hB38B8890,
                              32'h3EA8B96B,32'h3299ACE4,32'h30924DD4,32'h55CB34A5};
  logic [31:0] tc256 [16] = '{32'hB405F031,32'hC4233EBA,32'hB3733979,32'hC0DD9D55,32'hC51C28AE,32'hA327B8E1,
                              32'h56C56167,32'hED614433,32'h88B59D60,32'h60E2CEBA,32'h758B4B8B,32'h83E82A7F,
                              32'hBC968828,32'hE6E00BF7,32'hBA839E55,32'h9B491C60};
  logic [31:0] ta512 [12] = '{32'h20728DFD,32'h46C0BD53,32'hE782B699,32'h55304632,32'h71B4EF90,32'h0EA9E82C,
                              32'hDBB930F1,32'hFAD06B8B,32'hBE0CAE40,32'h8BD14410,32'h76D2ADAC,32'h28ACAB7F};
  logic [31:0] tb512 [16] = '{32'hC1099CB7,32'h07B385F3,32'hE7442C26,32'hCC8AD640,32'hEB6F56C7,32'h1EA81AA9,
                              32'h73B9D314,32'h1DE85D08,32'h48910A5A,32'h893B22DB,32'hC5A0DF44,32'hBBC4324E,
                              32'h72D2F240,32'h75941D99,32'h6D8BDE82,32'hA1A7502B};
  logic [31:0] tc512 [16] = '{32'hD9BF68D1,32'h58BAD750,32'h56028CB2,32'h8134F359,32'hB5D469D8,32'h941A8CC2,
                              32'h418B2A6E,32'h04052780,32'h7F07D787,32'h5194358F,32'h3C60D665,32'hBE97D79A,
                              32'h950C3434,32'hAED9A06D,32'h2537DC8D,32'h7CDB5969};

  function automatic logic [31:0] rl(logic [31:0] x, int r);
    return (x << r) | (x >> (32 - r));
  endfunction

  task automatic ref_init(input logic w512);
    rwide = w512;
    for (int k = 0; k < 12; k++) ra[k] = w512 ? ta512[k] : ta256[k];
    for (int k = 0; k < 16; k++) begin
      rb[k] = w512 ? tb512[k] : tb256[k];
      rc[k] = w512 ? tc512[k] : tc256[k];
    end
    rw = {32'd0, LO0};
  endtask

  task automatic ref_perm();
    logic [31:0] t;
    ra[0] = ra[0] ^ rw[31:0];
    ra[1] = ra[1] ^ rw[63:32];
    for (int j = 0; j < 16; j++) rb[j] = rl(rb[j], 17);
    for (int i = 0; i < 48; i++) begin
      int j, ai, ap;
      j = i % 16; ai = i % 12; ap = (i + 11) % 12;
      t = rl(ra[ap], 15) * 32'd5;
      t = (ra[ai] ^ rc[(24 - j) % 16] ^ t) * 32'd3;
      ra[ai] = rm[j] ^ rb[(j+13)%16] ^ (rb[(j+9)%16] & ~rb[(j+6)%16]) ^ t;
      rb[j]  = ~(rl(rb[j], 1) ^ ra[ai]);
    end
    for (int s = 0; s < 36; s++) ra[11 - (s % 12)] += rc[(54 - s) % 16];
  endtask

  task automatic ref_swap();
    logic [31:0] t;
    for (int j = 0; j < 16; j++) begin t = rb[j]; rb[j] = rc[j]; rc[j] = t; end
  endtask

  task automatic ref_block(input logic [511:0] d);
    for (int j = 0; j < 16; j++) begin rm[j] = d[32*j +: 32]; rb[j] += rm[j]; end
    ref_perm();
    for (int j = 0; j < 16; j++) rc[j] -= rm[j];
    ref_swap();
    rw = rw + 64'd1;
  endtask

  task automatic ref_final(input logic [7:0] ub, input logic [2:0] n);
    logic [7:0] z;
    z = 8'h80 >> n;
    for (int j = 0; j < 16; j++) rm[j] = 32'd0;
    rm[0] = {24'd0, ((ub & -z) | z)};
    for (int j = 0; j < 16; j++) rb[j] += rm[j];
    ref_perm();
    for (int r = 0; r < 3; r++) begin ref_swap(); ref_perm(); end
    for (int k = 0; k < 16; k++) ex[k] = rwide ? rb[k] : rb[(8 + k) % 16];
  endtask

  // ---------------- checks and drivers ----------------
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (!blk_ready) @(negedge clk);
  endtask

  // garbage pulses while busy: must not alter anything (R9)
  task automatic poke_busy();
    repeat (5) @(negedge clk);
    blk_valid = 1; blk_data = {16{$urandom()}}; fin = 1; init = 1; wide = ~rwide;
    @(negedge clk);
    blk_valid = 0; fin = 0; init = 0;
  endtask

  task automatic send_block(input logic [511:0] d, input bit also_fin, input bit also_init, input bit poke);
    wait_idle();
    blk_valid = 1; blk_data = d; fin = also_fin; init = also_init; wide = ~rwide;
    @(negedge clk);
    blk_valid = 0; fin = 0; init = 0;
    ref_block(d);
    chk(!blk_ready, "R3 ready low after accept", {63'd0, blk_ready}, 64'd0);
    if (poke) poke_busy();
  endtask

  task automatic do_init(input logic w512);
    wait_idle();
    init = 1; wide = w512;
    @(negedge clk);
    init = 0;
    ref_init(w512);
  endtask

  task automatic do_fin(input logic [7:0] ub, input logic [2:0] n, input string tag, input bit poke);
    int cnt, last_at, bad;
    wait_idle();
    fin = 1; fin_ub = ub; fin_n = n;
    @(negedge clk);
    fin = 0;
    ref_final(ub, n);
    if (poke) poke_busy();
    while (!dig_valid) @(negedge clk);
    cnt = 0; last_at = -1; bad = 0;
    while (dig_valid) begin
      if (cnt < 16 && dig_word !== ex[cnt]) begin
        bad++;
        if (bad == 1) chk(0, {"R8 word ", tag}, {32'd0, dig_word}, {32'd0, ex[cnt]});
      end
      if (dig_last) last_at = cnt;
      cnt++;
      @(negedge clk);
    end
    if (bad == 0) chk(1, {"R7 digest ", tag}, 0, 0);
    chk(cnt == (rwide ? 16 : 8), {"R8 count ", tag}, cnt, rwide ? 16 : 8);
    chk(last_at == cnt - 1, {"R8 last ", tag}, last_at, cnt - 1);
    chk(blk_ready == 1'b1, {"R10 ready after digest ", tag}, {63'd0, blk_ready}, 64'd1);
    ref_init(rwide);
  endtask

  function automatic logic [511:0] rnd_blk();
    logic [511:0] d;
    for (int j = 0; j < 16; j++) d[32*j +: 32] = $urandom();
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ref_init(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(blk_ready == 1'b1, "R1 ready after reset", {63'd0, blk_ready}, 64'd1);
    chk(dig_valid == 1'b0, "R1 no digest after reset", {63'd0, dig_valid}, 64'd0);

    // R1/R6: reset state, empty message, marker only
    do_fin(8'h00, 3'd0, "R1 empty256", 0);
    // R2/R6: 512-bit reload, extra bits with n=7
    do_init(1'b1);
    do_fin(8'hFF, 3'd7, "R2 empty512 R6", 0);
    // R4 R5: three blocks cross the low-word carry
    do_init(1'b0);
    send_block({16{32'hFFFF_FFFF}}, 0, 0, 0);
    send_block('0, 0, 0, 1);
    send_block(rnd_blk(), 0, 0, 0);
    do_fin(8'hA5, 3'd3, "R4 R5 three256", 1);
    // R11: block beats init and fin
    do_init(1'b1);
    send_block(rnd_blk(), 1, 1, 0);
    chk(rwide == 1'b1, "R11 ref mode", {63'd0, rwide}, 64'd1);
    do_fin(8'h3C, 3'd5, "R11 priority512", 0);
    // R10: auto-reload, next message without init
    send_block(rnd_blk(), 0, 0, 1);
    do_fin(8'h00, 3'd1, "R10 reload512", 0);

    // random messages
    for (int m = 0; m < 8; m++) begin
      int nb;
      do_init(1'($urandom() & 1));
      nb = $urandom() % 5;
      for (int b = 0; b < nb; b++) send_block(rnd_blk(), 0, 0, ($urandom() % 3) == 0);
      do_fin(8'($urandom()), 3'($urandom()), "R9 random", ($urandom() % 2) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule